// File: doc/BRIEF.md
# Strap-Configured Serial Audio Output Port

This block turns decoded stereo subframe words into a three-wire serial audio stream: a bit clock, a word clock and serial data. It has no control registers. Its mode is taken from strap pins while reset is held, and it is fixed from then on. One strap decides whether the port drives its own clocks (master) or follows clocks from outside (slave). A 2-bit strap code picks one of four data formats: left-justified, I²S with 24-bit data, right-justified, or the raw subframe word.

Each input word is 28 bits wide: bits 27:4 hold the 24-bit audio sample with its MSB at bit 27, bit 3 is the validity flag, bit 2 the user bit, bit 1 the channel-status bit and bit 0 the parity bit. A pulse on `in_valid` stores a left/right pair as pending. The pending pair becomes the current pair at the first bit of the next left channel slot. In master mode the port also drives the channel-status and user bits of the channel being sent.

Top module: `sap_strap_tx`

## Requirements
- R1: `strap_master` and `strap_fmt` are registered on every clock edge while `rst` is high. The value held at the last such edge sets the mode. Changing the straps after reset has no effect on any output.
- R2: When `strap_master` was 1, `is_master` is 1. `sclk_out` is the clock divided by 4: two cycles low, then two cycles high, starting low on the first edge after reset. A frame holds 64 bits, 32 slots per channel.
- R3: In master mode, `sdata` and `lrck_out` change only on the edge that drives `sclk_out` low. Data is sent MSB first.
- R4: Format code 00 (left-justified): `lrck_out` is high for the left channel. The sample MSB is in slot 0 and slots 24 to 31 are low.
- R5: Format code 01 (I²S): `lrck_out` is low for the left channel. Slot 0 is low, the MSB is in slot 1 and slots 25 to 31 are low.
- R6: Format code 10 (right-justified, master only): slots 0 to 7 are low, the MSB is in slot 8 and the LSB is in slot 31.
- R7: Format code 11 (raw): the whole 28-bit subframe word is sent MSB first in slots 0 to 27. Slots 28 to 31 are low.
- R8: When slave mode is strapped together with code 10, the port runs left-justified and `cfg_err` is 1. Every other strap setting gives `cfg_err` = 0.
- R9: A word whose validity bit is set, or whose parity bit is wrong, is sent exactly like any other word.
- R10: In master mode, `cbit` and `ubit` carry bits 1 and 2 of the word for the channel being sent. They change only when `lrck_out` changes. In slave mode both stay low.
- R11: In slave mode, the port detects falling edges of `sclk_in` through a two-stage synchronizer. It registers the next data bit on the third clock edge after the fall. A change of `lrck_in` starts a new channel slot at slot 0. Left is `lrck_in` high, or low for I²S. `sclk_out` and `lrck_out` stay low.
- R12: A pair loaded with `in_valid` is sent starting with the next frame's left slot 0. Reset clears the held pairs and drives every serial output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_master | input | 1 | Strap: 1 = port drives clocks, 0 = port follows clocks |
| strap_fmt | input | 2 | Strap: format code |
| in_valid | input | 1 | Loads `in_left`/`in_right` as the pending pair |
| in_left | input | 28 | Left subframe word |
| in_right | input | 28 | Right subframe word |
| sclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External word clock (slave mode) |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated word clock (master mode) |
| sdata | output | 1 | Serial audio data |
| cbit | output | 1 | Channel-status bit of the current channel (master mode) |
| ubit | output | 1 | User bit of the current channel (master mode) |
| is_master | output | 1 | Latched master/slave choice |
| cfg_err | output | 1 | Slave mode with right-justified was strapped |

## Verification
Several properties are checked on every cycle:
- Once reset ends, the latched mode and `cfg_err` do not move.
- `cfg_err` never appears together with master mode.
- In master mode, data and word clock change only while the bit clock is low.
- Status and user bits change only with the word clock.
- In slave mode, the clock outputs and status outputs stay quiet.

Only the bench scenarios can show the slot position of every bit in each of the four formats. The same holds for the divide-by-4 clock phase, when a pending pair is picked up, the fallback from slave right-justified, and the data latency after a falling edge of the external bit clock.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RAW = 2'b11
  } sap_fmt_e;

  typedef struct packed {
    logic     master;
    sap_fmt_e fmt;
  } sap_cfg_t;
endpackage

// File: rtl/sap_cfg_latch.sv
module sap_cfg_latch
  import sap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_master,
  input  logic [1:0] strap_fmt,
  output sap_cfg_t   cfg,
  output logic       cfg_err
);
  sap_fmt_e req_fmt;
  logic     bad_combo;

  assign req_fmt   = sap_fmt_e'(strap_fmt);
  assign bad_combo = !strap_master && (req_fmt == FMT_RJ);

  // Straps are followed while reset is high; the last value is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.master <= strap_master;
      cfg.fmt    <= bad_combo ? FMT_LJ : req_fmt;
      cfg_err    <= bad_combo;
    end
  end
endmodule

// File: rtl/sap_timing.sv
module sap_timing #(
  parameter  int SLOT_BITS = 32,
  parameter  int MCLK_DIV  = 4,
  localparam int KW        = $clog2(SLOT_BITS),
  localparam int DW        = $clog2(MCLK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          i2s,
  input  logic          sclk_in,
  input  logic          lrck_in,
  output logic          upd,
  output logic          load,
  output logic          right,
  output logic [KW-1:0] k,
  output logic          sclk_lvl
);
  localparam logic [DW-1:0] MC_LAST = DW'(MCLK_DIV - 1);
  localparam logic [KW-1:0] K_LAST  = KW'(SLOT_BITS - 1);

  // master-side divider and frame position
  logic [DW-1:0] mc;
  logic [KW:0]   mslot;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc    <= '0;
      mslot <= '0;
    end else if (master) begin
      mc <= mc + 1'b1;
      if (mc == MC_LAST) mslot <= mslot + 1'b1;
    end
  end

  // slave-side synchronizers and slot tracking
  logic [2:0]    sck_sync;
  logic [1:0]    lr_sync;
  logic          lr_last;
  logic [KW-1:0] sk;
  logic          s_fall, s_lr, s_edge, s_right;
  logic [KW-1:0] s_k;

  assign s_fall  = sck_sync[2] & ~sck_sync[1];
  assign s_lr    = lr_sync[1];
  assign s_edge  = s_lr ^ lr_last;
  assign s_right = s_lr ^ ~i2s;
  assign s_k     = s_edge ? '0 : ((sk == K_LAST) ? K_LAST : sk + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync <= '0;
      lr_sync  <= '0;
      lr_last  <= 1'b0;
      sk       <= K_LAST;
    end else begin
      sck_sync <= {sck_sync[1:0], sclk_in};
      lr_sync  <= {lr_sync[0], lrck_in};
      if (s_fall) begin
        lr_last <= s_lr;
        sk      <= s_k;
      end
    end
  end

  always_comb begin
    if (master) begin
      upd   = 1'b1;
      load  = (mc == '0) && (mslot == '0);
      right = mslot[KW];
      k     = mslot[KW-1:0];
    end else begin
      upd   = s_fall;
      load  = s_fall & s_edge & ~s_right;
      right = s_right;
      k     = s_k;
    end
    sclk_lvl = mc[DW-1];
  end
endmodule

// File: rtl/sap_serializer.sv
module sap_serializer
  import sap_pkg::*;
#(
  parameter  int AUD_W     = 24,
  parameter  int SF_W      = 28,
  parameter  int SLOT_BITS = 32,
  localparam int KW        = $clog2(SLOT_BITS),
  localparam int C_POS     = 1,
  localparam int U_POS     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  sap_cfg_t        cfg,
  input  logic            upd,
  input  logic            load,
  input  logic            right,
  input  logic [KW-1:0]   k,
  input  logic            sclk_lvl,
  input  logic            in_valid,
  input  logic [SF_W-1:0] in_left,
  input  logic [SF_W-1:0] in_right,
  output logic            sclk_out,
  output logic            lrck_out,
  output logic            sdata,
  output logic            cbit,
  output logic            ubit
);
  localparam logic [KW-1:0] K_LAST = KW'(SLOT_BITS - 1);

  logic [SF_W-1:0]      pend_l, pend_r, cur_l, cur_r;
  logic [SF_W-1:0]      src_l, src_r, word;
  logic [AUD_W-1:0]     aud;
  logic [SLOT_BITS-1:0] slot_vec;
  logic                 i2s;

  assign i2s   = (cfg.fmt == FMT_I2S);
  assign src_l = load ? pend_l : cur_l;
  assign src_r = load ? pend_r : cur_r;
  assign word  = right ? src_r : src_l;
  assign aud   = word[SF_W-1 -: AUD_W];

  // One channel slot laid out MSB-first per format
  always_comb begin
    unique case (cfg.fmt)
      FMT_LJ:  slot_vec = {aud, {(SLOT_BITS - AUD_W){1'b0}}};
      FMT_I2S: slot_vec = {1'b0, aud, {(SLOT_BITS - AUD_W - 1){1'b0}}};
      FMT_RJ:  slot_vec = {{(SLOT_BITS - AUD_W){1'b0}}, aud};
      default: slot_vec = {word, {(SLOT_BITS - SF_W){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l   <= '0;
      pend_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      sclk_out <= 1'b0;
      lrck_out <= 1'b0;
      sdata    <= 1'b0;
      cbit     <= 1'b0;
      ubit     <= 1'b0;
    end else begin
      if (in_valid) begin
        pend_l <= in_left;
        pend_r <= in_right;
      end
      if (upd) begin
        if (load) begin
          cur_l <= pend_l;
          cur_r <= pend_r;
        end
        sclk_out <= cfg.master & sclk_lvl;
        lrck_out <= cfg.master & (~right ^ i2s);
        sdata    <= slot_vec[K_LAST - k];
        cbit     <= cfg.master & word[C_POS];
        ubit     <= cfg.master & word[U_POS];
      end
    end
  end
endmodule

// File: rtl/sap_strap_tx.sv
module sap_strap_tx
  import sap_pkg::*;
#(
  parameter  int AUD_W     = 24,
  parameter  int SF_W      = 28,
  parameter  int SLOT_BITS = 32,
  parameter  int MCLK_DIV  = 4,
  localparam int KW        = $clog2(SLOT_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_master,
  input  logic [1:0]      strap_fmt,
  input  logic            in_valid,
  input  logic [SF_W-1:0] in_left,
  input  logic [SF_W-1:0] in_right,
  input  logic            sclk_in,
  input  logic            lrck_in,
  output logic            sclk_out,
  output logic            lrck_out,
  output logic            sdata,
  output logic            cbit,
  output logic            ubit,
  output logic            is_master,
  output logic            cfg_err
);
  sap_cfg_t      cfg;
  logic          upd, load, right, sclk_lvl;
  logic [KW-1:0] k;

  sap_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .strap_master(strap_master), .strap_fmt(strap_fmt),
    .cfg(cfg), .cfg_err(cfg_err)
  );

  sap_timing #(.SLOT_BITS(SLOT_BITS), .MCLK_DIV(MCLK_DIV)) u_tim (
    .clk(clk), .rst(rst), .master(cfg.master), .i2s(cfg.fmt == FMT_I2S),
    .sclk_in(sclk_in), .lrck_in(lrck_in),
    .upd(upd), .load(load), .right(right), .k(k), .sclk_lvl(sclk_lvl)
  );

  sap_serializer #(.AUD_W(AUD_W), .SF_W(SF_W), .SLOT_BITS(SLOT_BITS)) u_ser (
    .clk(clk), .rst(rst), .cfg(cfg), .upd(upd), .load(load), .right(right),
    .k(k), .sclk_lvl(sclk_lvl), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .sclk_out(sclk_out), .lrck_out(lrck_out),
    .sdata(sdata), .cbit(cbit), .ubit(ubit)
  );

  assign is_master = cfg.master;
endmodule

// File: rtl/sap_strap_tx_chk.sv
module sap_strap_tx_chk (
  input logic clk,
  input logic rst,
  input logic sclk_out,
  input logic lrck_out,
  input logic sdata,
  input logic cbit,
  input logic ubit,
  input logic is_master,
  input logic cfg_err
);
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end
  assign armed = age >= 2'd2;

  assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($stable(is_master) && $stable(cfg_err)));

  assert_err_only_slave_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !is_master);

  assert_change_on_low_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && is_master && (sdata != $past(sdata) || lrck_out != $past(lrck_out)))
    |-> !sclk_out);

  assert_cu_follow_lr_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && is_master && (cbit != $past(cbit) || ubit != $past(ubit)))
    |-> (lrck_out != $past(lrck_out)));

  assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !is_master |-> (!sclk_out && !lrck_out && !cbit && !ubit));
endmodule

bind sap_strap_tx sap_strap_tx_chk u_chk (
  .clk(clk), .rst(rst), .sclk_out(sclk_out), .lrck_out(lrck_out), .sdata(sdata),
  .cbit(cbit), .ubit(ubit), .is_master(is_master), .cfg_err(cfg_err)
);

// File: tb/sap_strap_tx_test.sv
module sap_strap_tx_test;
  localparam int SF_W = 28;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst = 1'b1, strap_master = 1'b0;
  logic [1:0]      strap_fmt = 2'b00;
  logic            in_valid = 1'b0;
  logic [SF_W-1:0] in_left = '0, in_right = '0;
  logic            sclk_in = 1'b0, lrck_in = 1'b0;
  logic            sclk_out, lrck_out, sdata, cbit, ubit, is_master, cfg_err;

  int checks = 0;
  int bad = 0;

  // test pairs: {audio24, V, U, C, P}
  localparam logic [SF_W-1:0] L0 = {24'hC35A96, 4'b1011};
  localparam logic [SF_W-1:0] R0 = {24'h5A0F3C, 4'b0100};
  localparam logic [SF_W-1:0] L1 = {24'h800001, 4'b0010};
  localparam logic [SF_W-1:0] R1 = {24'hFFFFFF, 4'b1110};
  localparam logic [SF_W-1:0] L2 = {24'h123456, 4'b0001};
  localparam logic [SF_W-1:0] R2 = {24'hEDCBA9, 4'b1000};

  sap_strap_tx uut (
    .clk(clk), .rst(rst), .strap_master(strap_master), .strap_fmt(strap_fmt),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .sclk_in(sclk_in), .lrck_in(lrck_in), .sclk_out(sclk_out), .lrck_out(lrck_out),
    .sdata(sdata), .cbit(cbit), .ubit(ubit), .is_master(is_master), .cfg_err(cfg_err)
  );

  function automatic logic ref_bit(int f, int k, logic [SF_W-1:0] w);
    logic [23:0] a;
    a = w[27:4];
    case (f)
      0: return (k < 24) ? a[23-k] : 1'b0;
      1: return (k >= 1 && k <= 24) ? a[24-k] : 1'b0;
      2: return (k >= 8) ? a[31-k] : 1'b0;
      default: return (k < 28) ? w[27-k] : 1'b0;
    endcase
  endfunction

  function automatic string fmt_tag(int f);
    case (f)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic m, logic [1:0] f);
    rst = 1'b1; strap_master = m; strap_fmt = f;
    in_valid = 1'b0; sclk_in = 1'b0; lrck_in = 1'b0;
    repeat (3) tick();
    chk("R12", "sclk_out in reset", 32'(sclk_out), 0);
    chk("R12", "lrck_out in reset", 32'(lrck_out), 0);
    chk("R12", "sdata in reset", 32'(sdata), 0);
    chk("R8", "cfg_err", 32'(cfg_err), 32'(!m && f == 2'b10));
    rst = 1'b0;
  endtask

  task automatic run_master(int f, bit wiggle);
    logic [SF_W-1:0] pl, pr, cl, cr, w, dl, dr;
    logic vin;
    int c, slot, k;
    bit rt;
    do_reset(1'b1, 2'(f));
    pl = '0; pr = '0; cl = '0; cr = '0;
    for (int n = 1; n <= 3 * 256 + 4; n++) begin
      in_valid = 1'b0;
      if (n == 100) begin in_valid = 1'b1; in_left = L0; in_right = R0; end
      if (n == 356) begin in_valid = 1'b1; in_left = L1; in_right = R1; end
      if (n == 612) begin in_valid = 1'b1; in_left = L2; in_right = R2; end
      if (wiggle && n == 40) begin strap_master = 1'b0; strap_fmt = 2'b10; end
      vin = in_valid; dl = in_left; dr = in_right;
      tick();
      c = n - 1;
      if (c % 256 == 0) begin cl = pl; cr = pr; end  // R12 pickup at frame start
      if (vin) begin pl = dl; pr = dr; end
      slot = (c / 4) % 64; k = slot % 32; rt = (slot >= 32);
      w = rt ? cr : cl;
      chk("R2", "sclk_out", 32'(sclk_out), 32'((c % 4) >= 2));
      chk((f == 1) ? "R5" : "R3", "lrck_out", 32'(lrck_out), 32'(rt ? (f == 1) : (f != 1)));
      chk(w[3] ? "R9" : fmt_tag(f), "sdata", 32'(sdata), 32'(ref_bit(f, k, w)));
      chk("R10", "cbit", 32'(cbit), 32'(w[1]));
      chk("R10", "ubit", 32'(ubit), 32'(w[2]));
      if (n % 64 == 0) begin
        chk(wiggle ? "R1" : "R2", "is_master", 32'(is_master), 1);
        chk(wiggle ? "R1" : "R8", "cfg_err", 32'(cfg_err), 0);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic run_slave(logic [1:0] sf);
    int ef;
    logic lv_left, lv;
    logic [SF_W-1:0] pl, pr, cl, cr;
    bit rt;
    int k;
    ef = (sf == 2'b10) ? 0 : int'(sf);
    lv_left = (ef != 1);
    do_reset(1'b0, sf);
    in_valid = 1'b1; in_left = L1; in_right = R0;
    tick();
    in_valid = 1'b0; pl = L1; pr = R0; cl = '0; cr = '0;
    sclk_in = 1'b1;
    repeat (4) tick();
    // one bit of the right channel before the first frame
    sclk_in = 1'b0; lrck_in = ~lv_left;
    repeat (4) tick();
    sclk_in = 1'b1;
    repeat (4) tick();
    for (int fr = 0; fr < 3; fr++) begin
      for (int b = 0; b < 64; b++) begin
        rt = (b >= 32); k = b % 32;
        lv = rt ? ~lv_left : lv_left;
        if (b == 0) begin cl = pl; cr = pr; end
        sclk_in = 1'b0; lrck_in = lv;
        if (b == 10) begin
          in_valid = 1'b1;
          in_left  = (fr == 0) ? L2 : R1;
          in_right = (fr == 0) ? R2 : L0;
          tick();
          in_valid = 1'b0; pl = in_left; pr = in_right;
          repeat (3) tick();
        end else begin
          repeat (4) tick();
        end
        sclk_in = 1'b1;
        repeat (4) tick();
        chk((sf == 2'b10) ? "R8" : "R11", "slave sdata", 32'(sdata),
            32'(ref_bit(ef, k, rt ? cr : cl)));
        chk("R11", "slave clocks out", 32'({sclk_out, lrck_out}), 0);
        chk("R10", "slave c/u", 32'({cbit, ubit}), 0);
      end
    end
    chk("R2", "is_master slave", 32'(is_master), 0);
    chk("R8", "cfg_err slave", 32'(cfg_err), 32'(sf == 2'b10));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    run_master(0, 1'b1);
    run_master(1, 1'b0);
    run_master(2, 1'b0);
    run_master(3, 1'b0);
    run_slave(2'b00);
    run_slave(2'b10);
    run_slave(2'b01);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule